// File: doc/BRIEF.md
# E1 Transmit Frame Timing Generator

This block produces the transmit timing of one E1 line. A prescaler turns the system clock into a bit strobe. Counters track the bit position within a 256-bit frame and the frame number within a multiframe. From these the block decodes the timeslot number, a frame sync pulse and a multiframe sync pulse.

The block also serialises payload. One bit period before each timeslot begins, it raises a one-clock byte request. The upstream buffer answers with the byte for the coming timeslot. That byte is then shifted out with B1 (byte bit 7) first and B8 (byte bit 0) last.

Three configuration inputs control the multiframe pulse:
- Structured or unstructured service.
- Double-frame period (2 frames) or CRC multiframe period (16 frames).
- Output polarity.

A change of service or period is taken up only at the next multiframe boundary. The polarity input acts at once.

Top module: `e1_tx_frame_gen`

## Requirements
- R1: While `rst_n` is low and directly after it rises, `bit_pos` is 0, `ts_idx` is 0, `frm_sync` is 1, `ser_out` is 0, `bit_stb` and `byte_req` are 0, and the multiframe pulse is active. The active mode after reset is structured, double-frame.
- R2: `bit_stb` is high for exactly one clock in every CLK_PER_BIT clocks, on the last clock of a bit period. `bit_pos` advances by one after each strobe, only then, and wraps from 255 to 0.
- R3: `ts_idx` equals `bit_pos` divided by 8, so it runs from 0 to 31.
- R4: `frm_sync` is 1 for the whole bit period in which `bit_pos` is 0, and 0 otherwise.
- R5: In structured double-frame mode, the multiframe pulse is active during bit 0 of every second frame and inactive everywhere else.
- R6: In structured CRC multiframe mode, the multiframe pulse is active during bit 0 of every sixteenth frame.
- R7: In unstructured mode, `mf_sync` stays at its inactive level on every clock.
- R8: `cfg_mf_pol` = 1 makes `mf_sync` active high, and 0 makes it active low. A polarity change shows on the next clock's sampled output without waiting for a boundary.
- R9: A change of `cfg_structured` or `cfg_crc_mf` takes effect at the end of the current multiframe, as counted in the old period. A new multiframe, with its pulse, starts there.
- R10: `byte_req` is high for one clock: the first clock of each bit period whose `bit_pos` modulo 8 is 7.
- R11: The byte on `byte_in` at the end of a requesting bit period is sent during the next timeslot, bit 7 first, one bit per bit period. Timeslot 0 of the first frame after reset sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_structured | input | 1 | 1 = structured service, 0 = unstructured |
| cfg_crc_mf | input | 1 | 1 = 16-frame multiframe, 0 = 2-frame multiframe |
| cfg_mf_pol | input | 1 | Multiframe pulse polarity, 1 = active high |
| byte_in | input | 8 | Byte for the next timeslot from the upstream buffer |
| bit_stb | output | 1 | One-clock strobe at the end of each bit period |
| bit_pos | output | 8 | Bit position in the frame, 0 to 255 |
| ts_idx | output | 5 | Current timeslot, 0 to 31 |
| frm_sync | output | 1 | Frame sync, high during bit 0 of each frame |
| mf_sync | output | 1 | Multiframe sync, polarity per `cfg_mf_pol` |
| byte_req | output | 1 | One-clock request for the next timeslot's byte |
| ser_out | output | 1 | Serial line data |

## Verification
A wrong bit counter shows within one bit period. `bit_pos`, `ts_idx`, `frm_sync` and the request strobe then fall out of step with the strobe count. A frame counter or latched mode that has gone astray shows only at frame starts. It appears as a multiframe pulse at the wrong frame, and can take up to sixteen frames to surface. The tests therefore follow the pulse across complete multiframes and across the mode switchover. A fault in the shift register or its load point shows within one timeslot, as a reordered or shifted byte on the line. It is caught by rebuilding a whole frame of bytes from `ser_out`.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

  localparam int unsigned SLOT_BITS = 8;   // bits per timeslot
  localparam int unsigned SLOTS     = 32;  // timeslots per frame
  localparam int unsigned MF_SHORT  = 2;   // double-frame period
  localparam int unsigned MF_LONG   = 16;  // CRC multiframe period

  typedef struct packed {
    logic structured;
    logic crc_mf;
  } mode_t;

endpackage

// File: rtl/e1tx_prescale.sv
module e1tx_prescale #(
  parameter int unsigned CLK_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_stb,
  output logic bit_first
);

  localparam int unsigned CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign bit_stb   = (cnt_q == CW'(CLK_PER_BIT - 1));
  assign bit_first = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (bit_stb) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/e1tx_counters.sv
module e1tx_counters
  import e1tx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned MF_S       = 2,
  parameter int unsigned MF_L       = 16,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS),
  localparam int unsigned FR_W      = $clog2(MF_L)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  mode_t            cfg_mode,
  output logic [POS_W-1:0] bit_pos,
  output logic [FR_W-1:0]  frame_idx,
  output mode_t            act_mode
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [FR_W-1:0]  fr_q, fr_d;
  mode_t            mode_q, mode_d;
  logic             frame_end;
  logic             period_end;

  assign frame_end  = (pos_q == POS_W'(FRAME_BITS - 1));
  assign period_end = mode_q.crc_mf ? (fr_q == FR_W'(MF_L - 1))
                                    : (fr_q == FR_W'(MF_S - 1));

  // Mode is taken up only where a multiframe under the old period ends.
  always_comb begin
    pos_d  = pos_q;
    fr_d   = fr_q;
    mode_d = mode_q;
    if (bit_stb) begin
      if (frame_end) begin
        pos_d = '0;
        if (period_end) begin
          fr_d   = '0;
          mode_d = cfg_mode;
        end else begin
          fr_d = fr_q + 1'b1;
        end
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fr_q   <= '0;
      mode_q <= '{structured: 1'b1, crc_mf: 1'b0};
    end else begin
      pos_q  <= pos_d;
      fr_q   <= fr_d;
      mode_q <= mode_d;
    end
  end

  assign bit_pos   = pos_q;
  assign frame_idx = fr_q;
  assign act_mode  = mode_q;

endmodule

// File: rtl/e1tx_pulses.sv
module e1tx_pulses #(
  parameter int unsigned POS_W = 8,
  parameter int unsigned SB_W  = 3,
  parameter int unsigned FR_W  = 4,
  localparam int unsigned TS_W = POS_W - SB_W
) (
  input  logic             bit_first,
  input  logic [POS_W-1:0] bit_pos,
  input  logic [FR_W-1:0]  frame_idx,
  input  logic             act_structured,
  input  logic             mf_pol,
  output logic [TS_W-1:0]  ts_idx,
  output logic             slot_last,
  output logic             frm_sync,
  output logic             mf_sync,
  output logic             byte_req
);

  logic mf_hit;

  assign ts_idx    = bit_pos[POS_W-1:SB_W];
  assign slot_last = &bit_pos[SB_W-1:0];
  assign frm_sync  = (bit_pos == '0);
  assign mf_hit    = act_structured && frm_sync && (frame_idx == '0);
  assign mf_sync   = mf_pol ? mf_hit : ~mf_hit;
  assign byte_req  = bit_first && slot_last;

endmodule

// File: rtl/e1tx_serializer.sv
module e1tx_serializer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_stb,
  input  logic         slot_last,
  input  logic [W-1:0] byte_in,
  output logic         ser_out
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (bit_stb) begin
      if (slot_last) sh_d = byte_in;
      else           sh_d = {sh_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_out = sh_q[W-1];

endmodule

// File: rtl/e1_tx_frame_gen.sv
module e1_tx_frame_gen
  import e1tx_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 4,
  parameter int unsigned SLOT_W      = SLOT_BITS,
  parameter int unsigned NUM_SLOTS   = SLOTS,
  parameter int unsigned MF_S        = MF_SHORT,
  parameter int unsigned MF_L        = MF_LONG,
  localparam int unsigned FRAME_BITS = SLOT_W * NUM_SLOTS,
  localparam int unsigned POS_W      = $clog2(FRAME_BITS),
  localparam int unsigned SB_W       = $clog2(SLOT_W),
  localparam int unsigned TS_W       = POS_W - SB_W,
  localparam int unsigned FR_W       = $clog2(MF_L)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_structured,
  input  logic              cfg_crc_mf,
  input  logic              cfg_mf_pol,
  input  logic [SLOT_W-1:0] byte_in,
  output logic              bit_stb,
  output logic [POS_W-1:0]  bit_pos,
  output logic [TS_W-1:0]   ts_idx,
  output logic              frm_sync,
  output logic              mf_sync,
  output logic              byte_req,
  output logic              ser_out
);

  logic            bit_first;
  logic            slot_last;
  logic [FR_W-1:0] frame_idx;
  mode_t           cfg_mode;
  mode_t           act_mode;

  assign cfg_mode = '{structured: cfg_structured, crc_mf: cfg_crc_mf};

  e1tx_prescale #(.CLK_PER_BIT(CLK_PER_BIT)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_first (bit_first)
  );

  e1tx_counters #(.FRAME_BITS(FRAME_BITS), .MF_S(MF_S), .MF_L(MF_L)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .cfg_mode  (cfg_mode),
    .bit_pos   (bit_pos),
    .frame_idx (frame_idx),
    .act_mode  (act_mode)
  );

  e1tx_pulses #(.POS_W(POS_W), .SB_W(SB_W), .FR_W(FR_W)) u_pls (
    .bit_first      (bit_first),
    .bit_pos        (bit_pos),
    .frame_idx      (frame_idx),
    .act_structured (act_mode.structured),
    .mf_pol         (cfg_mf_pol),
    .ts_idx         (ts_idx),
    .slot_last      (slot_last),
    .frm_sync       (frm_sync),
    .mf_sync        (mf_sync),
    .byte_req       (byte_req)
  );

  e1tx_serializer #(.W(SLOT_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .slot_last (slot_last),
    .byte_in   (byte_in),
    .ser_out   (ser_out)
  );

endmodule

// File: rtl/e1tx_chk.sv
module e1tx_chk #(
  parameter int unsigned POS_W      = 8,
  parameter int unsigned SB_W       = 3,
  parameter int unsigned FRAME_BITS = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic [POS_W-1:0] bit_pos,
  input logic             frm_sync,
  input logic             mf_sync,
  input logic             cfg_mf_pol,
  input logic             byte_req,
  input logic             ser_out
);

  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(bit_pos));

  p_pos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> (bit_pos == POS_W'($past(bit_pos) + 1'b1)));

  p_frame_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && bit_pos == POS_W'(FRAME_BITS - 1)) |=> frm_sync);

  p_mf_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_sync == cfg_mf_pol) |-> frm_sync);

  p_req_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> (&bit_pos[SB_W-1:0]));

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);

  p_ser_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ser_out));

endmodule

bind e1_tx_frame_gen e1tx_chk #(
  .POS_W(POS_W), .SB_W(SB_W), .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .bit_pos    (bit_pos),
  .frm_sync   (frm_sync),
  .mf_sync    (mf_sync),
  .cfg_mf_pol (cfg_mf_pol),
  .byte_req   (byte_req),
  .ser_out    (ser_out)
);

// File: tb/tb_e1_tx_frame_gen.sv
module tb_e1_tx_frame_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_structured = 1'b1;
  logic       cfg_crc_mf = 1'b0;
  logic       cfg_mf_pol = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic       bit_stb;
  logic [7:0] bit_pos;
  logic [4:0] ts_idx;
  logic       frm_sync, mf_sync, byte_req, ser_out;

  int   checks = 0;
  int   errors = 0;
  logic [7:0] salt = 8'h00;
  bit   done = 1'b0;

  e1_tx_frame_gen #(.CLK_PER_BIT(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_structured(cfg_structured),
    .cfg_crc_mf(cfg_crc_mf), .cfg_mf_pol(cfg_mf_pol), .byte_in(byte_in),
    .bit_stb(bit_stb), .bit_pos(bit_pos), .ts_idx(ts_idx),
    .frm_sync(frm_sync), .mf_sync(mf_sync), .byte_req(byte_req),
    .ser_out(ser_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int ts);
    return 8'(ts * 37 + 11) ^ salt;
  endfunction

  function automatic bit mf_on();
    return mf_sync == cfg_mf_pol;
  endfunction

  // Upstream buffer: answers each request with the next timeslot's byte.
  initial forever begin
    @(negedge clk);
    if (rst_n && byte_req) byte_in = pat((int'(ts_idx) + 1) % 32);
  end

  // Leaves the bench at the negedge in the first clock of the next bit.
  task automatic next_bit();
    do @(negedge clk); while (!bit_stb);
    @(negedge clk);
  endtask

  task automatic next_frame();
    do next_bit(); while (bit_pos != 8'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(bit_pos == 0 && ts_idx == 0, "R1 counters in reset", bit_pos, 0);
    rst_n = 1'b1;
    #1;
    chk(bit_pos == 0, "R1 bit_pos", bit_pos, 0);
    chk(ts_idx == 0, "R1 ts_idx", ts_idx, 0);
    chk(frm_sync == 1, "R1 frm_sync", frm_sync, 1);
    chk(mf_sync == 1, "R1 mf_sync active", mf_sync, 1);
    chk(ser_out == 0 && bit_stb == 0 && byte_req == 0, "R1 strobes and data",
        {ser_out, bit_stb, byte_req}, 0);
  endtask

  task automatic t_strobe();
    for (int i = 0; i < 12; i++) begin
      int n = 0;
      logic [7:0] p = bit_pos;
      do begin @(negedge clk); n++; end while (!bit_stb);
      chk(n == DIV - 1, "R2 strobe spacing", n, DIV - 1);
      @(negedge clk);
      chk(bit_pos == p + 8'd1, "R2 bit step", bit_pos, p + 1);
    end
    chk(frm_sync == 0, "R4 frm_sync off mid-frame", frm_sync, 0);
    while (bit_pos != 8'd15) next_bit();
    chk(ts_idx == 1, "R3 ts at bit 15", ts_idx, 1);
    next_bit();
    chk(ts_idx == 2, "R3 ts at bit 16", ts_idx, 2);
    while (bit_pos != 8'd255) next_bit();
    chk(ts_idx == 31, "R3 ts at bit 255", ts_idx, 31);
    next_bit();
    chk(bit_pos == 0 && ts_idx == 0, "R2 wrap to 0", bit_pos, 0);
    chk(frm_sync == 1, "R4 frm_sync at bit 0", frm_sync, 1);
    next_bit();
    chk(frm_sync == 0, "R4 frm_sync lasts one bit", frm_sync, 0);
  endtask

  task automatic t_double();
    int guard = 0;
    next_frame();
    while (!mf_on() && guard < 3) begin next_frame(); guard++; end
    chk(mf_on(), "R5 pulse found", mf_sync, cfg_mf_pol);
    next_bit();
    chk(!mf_on(), "R5 pulse lasts one bit", mf_sync, !cfg_mf_pol);
    for (int f = 1; f <= 6; f++) begin
      next_frame();
      chk(mf_on() == (f % 2 == 0), "R5 double-frame period", mf_on(), f % 2 == 0);
    end
  endtask

  task automatic t_serial();
    logic [255:0] bits;
    salt = 8'h5A;
    next_frame();
    next_frame();
    bits[0] = ser_out;
    for (int b = 1; b < 256; b++) begin
      next_bit();
      bits[bit_pos] = ser_out;
    end
    for (int ts = 0; ts < 32; ts++) begin
      logic [7:0] got;
      for (int k = 0; k < 8; k++) got[7-k] = bits[ts*8 + k];
      chk(got == pat(ts), "R11 timeslot byte", got, pat(ts));
    end
    while (bit_pos != 8'd7) next_bit();
    chk(byte_req == 1, "R10 request at bit 7", byte_req, 1);
    @(negedge clk);
    chk(byte_req == 0, "R10 request one clock", byte_req, 0);
    next_bit();
    chk(byte_req == 0, "R10 no request at bit 8", byte_req, 0);
  endtask

  task automatic t_crc();
    int bad = 0;
    int guard = 0;
    next_frame();
    while (!mf_on() && guard < 3) begin next_frame(); guard++; end
    cfg_crc_mf = 1'b1;
    next_frame();
    chk(!mf_on(), "R9 old period frame 1", mf_on(), 0);
    next_frame();
    chk(mf_on(), "R9 switch at boundary", mf_on(), 1);
    for (int f = 1; f < 16; f++) begin
      next_frame();
      if (mf_on()) bad++;
    end
    chk(bad == 0, "R6 no pulse frames 1..15", bad, 0);
    next_frame();
    chk(mf_on(), "R6 pulse at frame 16", mf_on(), 1);
  endtask

  task automatic t_switch();
    int bad = 0;
    for (int f = 1; f <= 3; f++) next_frame();
    cfg_crc_mf = 1'b0;
    for (int f = 4; f <= 15; f++) begin
      next_frame();
      if (mf_on()) bad++;
    end
    chk(bad == 0, "R9 long period completes", bad, 0);
    next_frame();
    chk(mf_on(), "R9 new multiframe at 16", mf_on(), 1);
    next_frame();
    chk(!mf_on(), "R9 double after switch odd", mf_on(), 0);
    next_frame();
    chk(mf_on(), "R9 double after switch even", mf_on(), 1);
  endtask

  task automatic t_unstruct();
    int bad = 0;
    int guard = 0;
    cfg_structured = 1'b0;
    for (int f = 0; f < 3; f++) next_frame();
    for (int i = 0; i < 4 * 256 * DIV; i++) begin
      @(negedge clk);
      if (i == 2 * 256 * DIV) begin
        cfg_mf_pol = 1'b0;
        #1;
        chk(mf_sync == 1, "R8 polarity acts at once", mf_sync, 1);
      end
      if (mf_sync != !cfg_mf_pol) bad++;
    end
    chk(bad == 0, "R7 unstructured inactive", bad, 0);
    cfg_structured = 1'b1;
    next_frame();
    while (mf_sync != 1'b0 && guard < 4) begin next_frame(); guard++; end
    chk(mf_sync == 0, "R8 active-low pulse", mf_sync, 0);
    next_bit();
    chk(mf_sync == 1, "R8 active-low idle", mf_sync, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_strobe();
    t_double();
    t_serial();
    t_crc();
    t_switch();
    t_unstruct();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule